// File: doc/BRIEF.md
# Satellite Control Tone-Gate Serialiser

This block turns a short control message for outdoor satellite equipment into a timing pattern on one output, `tone_en`. While `tone_en` is high, an external 22 kHz carrier generator is switched on. The host first writes the message bytes into a small internal store. It then pulses `start` with a byte count and a choice of trailing burst. The block produces the silent framing gaps, the pulse-width-coded bits with a parity bit after each byte, and the optional burst. It also produces the closing silence. Throughout the transfer it holds `busy` high, and it pulses `done` at the end.

All durations are whole microseconds. A per-phase divider of `CLK_PER_US` clock cycles turns them into clock cycles, so every phase lasts exactly its microsecond count times `CLK_PER_US` cycles. Two burst forms are offered. One is a single unbroken tone. The other is an all-ones byte sent with the normal bit coding. Generating the carrier, driving the line and listening for replies are handled elsewhere.

Top module: `sec_tone_tx`

## Requirements
- R1: After reset, `tone_en`, `busy` and `done` are all low, and `tone_en` stays low whenever `busy` is low.
- R2: A 1 bit is sent as `SHORT_US` of `tone_en` high followed by `LONG_US` of low. Each microsecond lasts `CLK_PER_US` clock cycles.
- R3: A 0 bit is sent as `LONG_US` high followed by `SHORT_US` low.
- R4: Each byte goes out bit 7 first down to bit 0. A ninth parity bit follows, and it makes the count of ones in those nine bits odd.
- R5: The first bit starts after `GAP_US` of low output that begins in the cycle after `start` is accepted. When at least one byte was sent, another `GAP_US` of low follows the last parity bit.
- R6: When `burst_sel` is 1 (tone burst), `tone_en` is driven high for `TONE_BURST_US` after the message gaps, then low.
- R7: When `burst_sel` is 2 (byte burst), the byte 8'hFF and its parity bit (a 1) are sent with the R2 coding after the message gaps.
- R8: After either burst form, `tone_en` stays low for `TAIL_US` before the transfer ends.
- R9: When `burst_sel` is 0 or 3 (no burst), the transfer ends at the end of the trailing gap.
- R10: A `msg_len` above `MAX_BYTES` is treated as `MAX_BYTES`. A `msg_len` of 0 sends only the leading gap followed by the chosen burst and its tail. With no burst chosen, it sends the leading gap alone.
- R11: While `busy` is high, `start` is ignored. Writes to the message store are also ignored then, so the bytes in the store stay unchanged.
- R12: `busy` is high from the cycle after an accepted `start` through the last cycle of the final phase. In the next cycle `done` is high for exactly one cycle and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one message byte into the store |
| wr_addr | input | AW | Byte position in the store (0 is sent first) |
| wr_data | input | 8 | Byte value to store |
| start | input | 1 | Begin a transfer (accepted only while idle) |
| msg_len | input | LW | Number of stored bytes to send |
| burst_sel | input | 2 | 0 or 3 no burst, 1 tone burst, 2 byte burst |
| tone_en | output | 1 | Registered carrier gate |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The situation hardest to reach from the ports is a fresh `start` plus a store write arriving in the middle of a transfer, together with a changed length and burst choice. A wrong design shows the damage only in a later transfer. The bench therefore drives that stimulus at a fixed cycle inside a running transfer. It then repeats the same transfer without reloading the store and compares both waveforms against a model built from the bytes it wrote earlier. Oversized lengths, zero length with each burst form, and the unused burst code are reached with directed cases. Random messages then mix all lengths and burst choices.

// File: rtl/sec_tx_pkg.sv
package sec_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_HI    = 3'd2,
    PH_LO    = 3'd3,
    PH_TRAIL = 3'd4,
    PH_BURST = 3'd5,
    PH_TAIL  = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_TONE  = 2'd1,
    BR_BYTE  = 2'd2,
    BR_NONE3 = 2'd3
  } burst_e;

  // Largest of the configured durations, used to size the microsecond counter.
  function automatic int unsigned longest_us(int unsigned a, int unsigned b,
                                             int unsigned c, int unsigned d,
                                             int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // Length of the current phase in microseconds; the bit value selects
  // which half of a pulse-width-coded bit is the long one.
  function automatic int unsigned phase_len_us(phase_e ph, logic bitv,
                                               int unsigned short_us,
                                               int unsigned long_us,
                                               int unsigned gap_us,
                                               int unsigned tone_us,
                                               int unsigned tail_us);
    case (ph)
      PH_LEAD, PH_TRAIL: return gap_us;
      PH_HI:             return bitv ? short_us : long_us;
      PH_LO:             return bitv ? long_us : short_us;
      PH_BURST:          return tone_us;
      PH_TAIL:           return tail_us;
      default:           return 0;
    endcase
  endfunction

endpackage

// File: rtl/sec_us_timer.sv
module sec_us_timer #(
  parameter int CLK_PER_US = 50,
  parameter int US_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  output logic            us_tick,
  output logic [US_W-1:0] elapsed
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;

  assign us_tick = (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      elapsed <= '0;
    end else if (restart) begin
      div_q   <= '0;
      elapsed <= '0;
    end else if (us_tick) begin
      div_q   <= '0;
      elapsed <= elapsed + 1'b1;
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sec_msg_store.sv
module sec_msg_store #(
  parameter int DEPTH = 10,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= 8'h00;
      else if (wr_en && (wr_addr == AW'(g)))
        slot[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr == AW'(i)) rd_data = slot[i];
  end
endmodule

// File: rtl/sec_tone_tx.sv
module sec_tone_tx
  import sec_tx_pkg::*;
#(
  parameter int CLK_PER_US    = 50,
  parameter int MAX_BYTES     = 10,
  parameter int SHORT_US      = 500,
  parameter int LONG_US       = 1000,
  parameter int GAP_US        = 16000,
  parameter int TONE_BURST_US = 12500,
  parameter int TAIL_US       = 20000,
  localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          start,
  input  logic [LW-1:0] msg_len,
  input  logic [1:0]    burst_sel,
  output logic          tone_en,
  output logic          busy,
  output logic          done
);
  localparam int US_W = $clog2(longest_us(SHORT_US, LONG_US, GAP_US,
                                          TONE_BURST_US, TAIL_US) + 1);
  localparam logic [LW-1:0] LEN_MAX = LW'(MAX_BYTES);

  phase_e        phase_q;
  burst_e        burst_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] byte_idx;
  logic [3:0]    bit_idx;
  logic          par_q;
  logic          in_burst_byte;
  logic          tone_q;
  logic          done_q;

  // Named internal events, also observed by the checker.
  logic            us_tick;
  logic [US_W-1:0] elapsed;
  logic            phase_end;
  logic            start_ok;
  logic            bit_val;
  logic            last_byte;
  logic [7:0]      rd_data;
  logic [7:0]      cur_byte;
  logic [2:0]      bit_sel;
  logic [31:0]     phase_us;
  phase_e          route_ph;

  assign busy    = (phase_q != PH_IDLE);
  assign tone_en = tone_q;
  assign done    = done_q;

  sec_msg_store #(.DEPTH(MAX_BYTES), .AW(AW)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && !busy),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (byte_idx[AW-1:0]),
    .rd_data (rd_data)
  );

  sec_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_ok || phase_end),
    .us_tick (us_tick),
    .elapsed (elapsed)
  );

  assign cur_byte  = in_burst_byte ? 8'hFF : rd_data;
  assign bit_sel   = 3'd7 - bit_idx[2:0];
  assign bit_val   = bit_idx[3] ? par_q : cur_byte[bit_sel];
  assign phase_us  = phase_len_us(phase_q, bit_val, SHORT_US, LONG_US,
                                  GAP_US, TONE_BURST_US, TAIL_US);
  assign phase_end = busy && us_tick && (elapsed == US_W'(phase_us - 1));
  assign start_ok  = start && !busy;
  assign last_byte = (byte_idx == LW'(len_q - 1'b1));

  always_comb begin
    case (burst_q)
      BR_TONE: route_ph = PH_BURST;
      BR_BYTE: route_ph = PH_HI;
      default: route_ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q       <= PH_IDLE;
      burst_q       <= BR_NONE;
      len_q         <= '0;
      byte_idx      <= '0;
      bit_idx       <= '0;
      par_q         <= 1'b1;
      in_burst_byte <= 1'b0;
      tone_q        <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_ok) begin
          phase_q       <= PH_LEAD;
          len_q         <= (msg_len > LEN_MAX) ? LEN_MAX : msg_len;
          burst_q       <= burst_e'(burst_sel);
          byte_idx      <= '0;
          bit_idx       <= '0;
          par_q         <= 1'b1;
          in_burst_byte <= 1'b0;
          tone_q        <= 1'b0;
        end
        PH_LEAD, PH_TRAIL: if (phase_end) begin
          if ((phase_q == PH_LEAD) && (len_q != '0)) begin
            phase_q <= PH_HI;
            tone_q  <= 1'b1;
          end else begin
            phase_q       <= route_ph;
            in_burst_byte <= (route_ph == PH_HI);
            bit_idx       <= '0;
            par_q         <= 1'b1;
            tone_q        <= (route_ph != PH_IDLE);
            done_q        <= (route_ph == PH_IDLE);
          end
        end
        PH_HI: if (phase_end) begin
          phase_q <= PH_LO;
          tone_q  <= 1'b0;
          if (!bit_idx[3]) par_q <= par_q ^ bit_val;
        end
        PH_LO: if (phase_end) begin
          if (!bit_idx[3]) begin
            bit_idx <= bit_idx + 1'b1;
            phase_q <= PH_HI;
            tone_q  <= 1'b1;
          end else if (in_burst_byte) begin
            phase_q <= PH_TAIL;
          end else if (!last_byte) begin
            byte_idx <= byte_idx + 1'b1;
            bit_idx  <= '0;
            par_q    <= 1'b1;
            phase_q  <= PH_HI;
            tone_q   <= 1'b1;
          end else begin
            phase_q <= PH_TRAIL;
          end
        end
        PH_BURST: if (phase_end) begin
          phase_q <= PH_TAIL;
          tone_q  <= 1'b0;
        end
        PH_TAIL: if (phase_end) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: begin
          phase_q <= PH_IDLE;
          tone_q  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sec_tone_tx_chk.sv
module sec_tone_tx_chk #(
  parameter int MAX_BYTES = 10,
  parameter int LW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tone_en,
  input logic          busy,
  input logic          done,
  input logic          start,
  input logic          phase_end,
  input logic [LW-1:0] len_q,
  input logic [3:0]    bit_idx
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tone_en);

  // R2/R3: the gate only moves when a timed phase has run out.
  p_edge_on_phase_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end |=> $stable(tone_en));

  p_bit_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= 4'd8);

  p_len_clamped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q <= LW'(MAX_BYTES)));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !phase_end) |=> busy);

  p_len_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q));

  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind sec_tone_tx sec_tone_tx_chk #(.MAX_BYTES(MAX_BYTES), .LW(LW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tone_en   (tone_en),
  .busy      (busy),
  .done      (done),
  .start     (start),
  .phase_end (phase_end),
  .len_q     (len_q),
  .bit_idx   (bit_idx)
);

// File: tb/sec_tone_tx_tb_top.sv
`timescale 1ns/1ps
module sec_tone_tx_tb_top;
  localparam int C  = 2;
  localparam int MB = 10;
  localparam int S  = 5;
  localparam int L  = 10;
  localparam int G  = 160;
  localparam int BA = 125;
  localparam int TL = 200;
  localparam int AW = 4;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          start = 1'b0;
  logic [LW-1:0] msg_len = '0;
  logic [1:0]    burst_sel = '0;
  logic          tone_en, busy, done;

  always #10 clk = ~clk;

  sec_tone_tx #(.CLK_PER_US(C), .MAX_BYTES(MB), .SHORT_US(S), .LONG_US(L),
                .GAP_US(G), .TONE_BURST_US(BA), .TAIL_US(TL)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .msg_len(msg_len),
    .burst_sel(burst_sel), .tone_en(tone_en), .busy(busy), .done(done));

  int   n_run = 0;
  int   n_fail = 0;
  bit   ended = 0;
  logic ew [0:4095];
  int   en;
  logic [7:0] mb [0:MB-1];

  task automatic chk(bit ok, string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic add(logic lvl, int us);
    for (int i = 0; i < us; i++) begin
      ew[en] = lvl;
      en++;
    end
  endtask

  task automatic add_bit(logic b);
    if (b) begin add(1'b1, S); add(1'b0, L); end
    else   begin add(1'b1, L); add(1'b0, S); end
  endtask

  task automatic add_byte(logic [7:0] d);
    logic p;
    p = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      p = p ^ d[i];
      add_bit(d[i]);
    end
    add_bit(p);
  endtask

  task automatic build(int len_req, int br);
    int n;
    en = 0;
    n = (len_req > MB) ? MB : len_req;
    add(1'b0, G);
    for (int b = 0; b < n; b++) add_byte(mb[b]);
    if (n > 0) add(1'b0, G);
    if (br == 1) begin add(1'b1, BA); add(1'b0, TL); end
    else if (br == 2) begin add_byte(8'hFF); add(1'b0, TL); end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    mb[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int len_req, int br, bit poke, string tag);
    int t, bad, at;
    logic act, expv;
    build(len_req, br);
    t = en * C;
    bad = 0; at = 0; act = 1'b0; expv = 1'b0;
    @(negedge clk);
    msg_len = LW'(len_req); burst_sel = 2'(br); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < t; j++) begin
      if (tone_en !== ew[j / C] || busy !== 1'b1) begin
        if (bad == 0) begin at = j; act = tone_en; expv = ew[j / C]; end
        bad++;
      end
      if (poke && j == 6) begin
        start = 1'b1; msg_len = LW'(1); burst_sel = 2'd1;
        wr_en = 1'b1; wr_addr = '0; wr_data = ~mb[0];
      end
      if (poke && j == 7) begin
        start = 1'b0; wr_en = 1'b0;
      end
      @(negedge clk);
    end
    chk(bad == 0, $sformatf("%s waveform len=%0d burst=%0d: cycle %0d tone_en=%b busy=%b expected tone_en=%b busy=1",
        tag, len_req, br, at, act, busy, expv));
    chk(done === 1'b1 && busy === 1'b0,
        $sformatf("R12 %s end at cycle %0d: done=%b busy=%b expected done=1 busy=0",
        tag, t, done, busy));
    @(negedge clk);
    chk(done === 1'b0, $sformatf("R12 %s done pulse: done=%b expected 0", tag, done));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired: ended=0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < MB; i++) mb[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(tone_en === 1'b0 && busy === 1'b0 && done === 1'b0,
        $sformatf("R1 reset: tone_en=%b busy=%b done=%b expected 0 0 0", tone_en, busy, done));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tone_en === 1'b0 && busy === 1'b0,
        $sformatf("R1 idle: tone_en=%b busy=%b expected 0 0", tone_en, busy));

    wr(0, 8'h00);
    run(1, 0, 0, "R3 R4 R5 R9 zero byte");
    wr(0, 8'hFF);
    run(1, 3, 0, "R2 R4 R9 ones byte, code 3");
    wr(0, 8'hA5); wr(1, 8'h3C);
    run(2, 1, 0, "R6 R8 tone burst");
    wr(2, 8'h81);
    run(3, 2, 0, "R7 R8 byte burst");
    run(0, 1, 0, "R10 empty with tone burst");
    run(0, 2, 0, "R10 empty with byte burst");
    run(0, 0, 0, "R10 empty no burst");
    for (int i = 0; i < MB; i++) wr(i, 8'(i * 37 + 11));
    run(13, 2, 0, "R10 length clamp");
    run(10, 0, 0, "R4 R5 full length");
    run(3, 1, 1, "R11 start and write while busy");
    run(3, 1, 0, "R11 store unchanged after busy write");

    for (int k = 0; k < 6; k++) begin
      int ln, br;
      ln = $urandom_range(0, 12);
      br = $urandom_range(0, 3);
      for (int i = 0; i < MB; i++) wr(i, 8'($urandom_range(0, 255)));
      run(ln, br, 0, "R2 R3 R4 R5 random");
    end

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule